// File: doc/BRIEF.md
# Linked-List DMA Descriptor Fetcher

This block serves one DMA channel that runs from a chain of descriptors held in memory. Software writes the address of the first descriptor, the initial source and destination addresses and a mode word, then raises the channel enable. The fetcher reads each seven-word descriptor through a 32-bit read port that allows one read in flight. It decodes the counts, the index values and the single address field. It then decides whether that address becomes the new source address, the new destination address, or neither. It gives the resulting parameter set to a transfer engine with a one-cycle start pulse and waits for the engine's done pulse.

After each transfer the fetcher either follows the descriptor's next pointer or, when that pointer holds the end marker, stops and pulses chain completion. A descriptor raises the block interrupt only when its own interrupt-enable bit is set. Software normally sets that bit only in the last descriptor. If the enable is cleared, the chain stops at the next state boundary. No interrupt is raised in that case.

Top module: `lldesc_fetcher`

## Requirements
- R1: After reset, `busy`, `rd_valid`, `xfer_start`, `irq_block` and `chain_done` are low and `desc_count` is zero.
- R2: A chain starts only on a rising edge of `chan_en` while `mode` bit 8 (list mode) is set. With bit 8 clear no read is issued. Keeping `chan_en` high after a chain ends does not start it again.
- R3: Each descriptor is read as seven words at byte addresses base+0, +4, ... +24, in that order. The first base is `first_ptr`. A request holds `rd_valid` and `rd_addr` steady until `rd_ready` accepts it.
- R4: Each descriptor produces exactly one one-cycle `xfer_start` pulse, issued after its seventh word is read. The parameters are valid during that pulse: element count = word1[23:0], frame count = word3[15:0], destination element index = word4[15:0], source element index = word4[31:16], destination frame index = word5, source frame index = word6.
- R5: For the first descriptor, the destination action is `mode`[1:0] and the source action is `mode`[3:2]. Action value 1 loads word2 into that side's address. Any other value (0, 2, 3) keeps the side's current address. The addresses start from `init_src` and `init_dst`, which are captured when the chain starts.
- R6: For each later descriptor, the source action comes from bits 25:24 of the previous descriptor's word1 and the destination action from bits 27:26, with the same encoding as R5.
- R7: `irq_block` pulses for one cycle, the cycle after `xfer_done` is accepted, if and only if bit 21 of that descriptor's word3 is set.
- R8: If word0 is not 0xFFFFFFFC, the next descriptor is fetched from that address. If it is 0xFFFFFFFC, `chain_done` pulses once, one cycle after the interrupt slot, and the block becomes idle.
- R9: `desc_count` is cleared when a chain starts and increments once for each `xfer_done` accepted while a transfer runs.
- R10: If `chan_en` is low when the seventh word arrives, or when `xfer_done` arrives, the block returns to idle. No further `xfer_start`, `irq_block` or `chain_done` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_en | input | 1 | Channel enable; a rising edge starts a chain |
| mode | input | 11 | Mode word: [1:0] dst action, [3:2] src action, [5:4] descriptor type, [8] list mode, [10] fast |
| first_ptr | input | 32 | Byte address of the first descriptor |
| init_src | input | 32 | Source address before the first descriptor |
| init_dst | input | 32 | Destination address before the first descriptor |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | 32 | Read byte address |
| rd_resp_valid | input | 1 | Read data valid |
| rd_resp_data | input | 32 | Read data |
| xfer_start | output | 1 | One-cycle start pulse to the transfer engine |
| xfer_done | input | 1 | Transfer engine finished the current descriptor |
| xfer_src_addr | output | 32 | Source address for the transfer |
| xfer_dst_addr | output | 32 | Destination address for the transfer |
| xfer_elem_cnt | output | 24 | Elements per frame |
| xfer_frame_cnt | output | 16 | Frames per block |
| xfer_src_eidx | output | 16 | Source element index |
| xfer_dst_eidx | output | 16 | Destination element index |
| xfer_src_fidx | output | 32 | Source frame index |
| xfer_dst_fidx | output | 32 | Destination frame index |
| irq_block | output | 1 | Per-descriptor block-complete interrupt pulse |
| chain_done | output | 1 | Chain finished at the end marker |
| desc_count | output | 16 | Descriptors completed in the current chain |
| busy | output | 1 | A chain is in progress |

## Verification
A wrong word counter or base register shows up as a wrong `rd_addr` on the very next read request, so the bench logs every accepted address and compares it with the descriptor layout. A wrong pending action or a stale address register shows up only at the next `xfer_start`. The bench sweeps all sixteen combinations of mode actions and follows chains whose per-descriptor actions vary. If the state machine leaves a transfer too early or too late, the result is an extra or missing start, an interrupt pattern different from the enable bits, or a `desc_count` that disagrees with the chain length. All of these are checked once each chain ends, together with both abort points.

// File: rtl/lldesc_pkg.sv
package lldesc_pkg;
  localparam int DESC_WORDS = 7;
  localparam int WIDX_W     = $clog2(DESC_WORDS);
  localparam logic [31:0] CHAIN_END = 32'hFFFF_FFFC;

  localparam int MODE_W     = 11;
  localparam int M_LIST_BIT = 8;

  localparam int W_NEXT  = 0;
  localparam int W_CTRL  = 1;
  localparam int W_ADDR  = 2;
  localparam int W_CNTIE = 3;
  localparam int W_EIDX  = 4;
  localparam int W_DFIDX = 5;
  localparam int W_SFIDX = 6;

  localparam int IE_BLOCK_BIT = 21;

  typedef enum logic [1:0] {ACT_KEEP = 2'd0, ACT_LOAD = 2'd1, ACT_REUSE = 2'd2, ACT_RSVD = 2'd3} act_e;
  typedef enum logic [2:0] {ST_IDLE, ST_FETCH, ST_LOAD, ST_RUN, ST_NEXT} st_e;
  typedef logic [DESC_WORDS-1:0][31:0] desc_t;
endpackage

// File: rtl/lldesc_reader.sv
module lldesc_reader
  import lldesc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] base,
  output logic        rd_valid,
  input  logic        rd_ready,
  output logic [31:0] rd_addr,
  input  logic        rd_resp_valid,
  input  logic [31:0] rd_resp_data,
  output desc_t       words,
  output logic        done
);
  logic              active_q, active_d;
  logic              req_q, req_d;
  logic [WIDX_W-1:0] idx_q, idx_d;
  logic [31:0]       base_q, base_d;
  logic              last_w, take;

  assign last_w = (idx_q == WIDX_W'(DESC_WORDS - 1));
  assign take   = active_q && !req_q && rd_resp_valid;

  always_comb begin
    active_d = active_q;
    req_d    = req_q;
    idx_d    = idx_q;
    base_d   = base_q;
    if (start) begin
      active_d = 1'b1;
      req_d    = 1'b1;
      idx_d    = '0;
      base_d   = base;
    end else if (active_q) begin
      if (req_q) begin
        if (rd_ready) req_d = 1'b0;
      end else if (rd_resp_valid) begin
        if (last_w) begin
          active_d = 1'b0;
        end else begin
          idx_d = idx_q + WIDX_W'(1);
          req_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      req_q    <= 1'b0;
      idx_q    <= '0;
      base_q   <= '0;
    end else begin
      active_q <= active_d;
      req_q    <= req_d;
      idx_q    <= idx_d;
      base_q   <= base_d;
    end
  end

  for (genvar g = 0; g < DESC_WORDS; g++) begin : g_word
    logic        cap;
    logic [31:0] wq;
    assign cap = take && (idx_q == WIDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   wq <= '0;
      else if (cap) wq <= rd_resp_data;
    end
    assign words[g] = wq;
  end

  assign rd_valid = active_q && req_q;
  assign rd_addr  = base_q + (32'(idx_q) << 2);
  assign done     = take && last_w;

  // R3: an unaccepted request keeps its address
  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));
endmodule

// File: rtl/lldesc_addr_sel.sv
module lldesc_addr_sel
  import lldesc_pkg::*;
(
  input  logic [1:0]  src_act,
  input  logic [1:0]  dst_act,
  input  logic [31:0] desc_addr,
  input  logic [31:0] cur_src,
  input  logic [31:0] cur_dst,
  output logic [31:0] new_src,
  output logic [31:0] new_dst
);
  assign new_src = (src_act == ACT_LOAD) ? desc_addr : cur_src;
  assign new_dst = (dst_act == ACT_LOAD) ? desc_addr : cur_dst;
endmodule

// File: rtl/lldesc_fetcher.sv
module lldesc_fetcher
  import lldesc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan_en,
  input  logic [MODE_W-1:0] mode,
  input  logic [31:0]       first_ptr,
  input  logic [31:0]       init_src,
  input  logic [31:0]       init_dst,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [31:0]       rd_addr,
  input  logic              rd_resp_valid,
  input  logic [31:0]       rd_resp_data,
  output logic              xfer_start,
  input  logic              xfer_done,
  output logic [31:0]       xfer_src_addr,
  output logic [31:0]       xfer_dst_addr,
  output logic [23:0]       xfer_elem_cnt,
  output logic [15:0]       xfer_frame_cnt,
  output logic [15:0]       xfer_src_eidx,
  output logic [15:0]       xfer_dst_eidx,
  output logic [31:0]       xfer_src_fidx,
  output logic [31:0]       xfer_dst_fidx,
  output logic              irq_block,
  output logic              chain_done,
  output logic [CNT_W-1:0]  desc_count,
  output logic              busy
);
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_sync_n, rst_meta_q} <= 2'b00;
    else        {rst_sync_n, rst_meta_q} <= {rst_meta_q, 1'b1};
  end

  st_e              st_q, st_d;
  logic             en_q;
  logic [31:0]      src_q, src_d, dst_q, dst_d;
  logic [1:0]       sact_q, sact_d, dact_q, dact_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             start_q, start_d, irq_q, irq_d, cdone_q, cdone_d;
  logic             rdr_start, rdr_done, launch;
  logic [31:0]      rdr_base, sel_src, sel_dst;
  desc_t            words;

  assign launch   = chan_en && !en_q && mode[M_LIST_BIT];
  assign rdr_base = (st_q == ST_IDLE) ? first_ptr : words[W_NEXT];

  lldesc_reader u_reader (
    .clk(clk), .rst_n(rst_sync_n), .start(rdr_start), .base(rdr_base),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data),
    .words(words), .done(rdr_done)
  );

  lldesc_addr_sel u_sel (
    .src_act(sact_q), .dst_act(dact_q), .desc_addr(words[W_ADDR]),
    .cur_src(src_q), .cur_dst(dst_q), .new_src(sel_src), .new_dst(sel_dst)
  );

  always_comb begin
    st_d      = st_q;
    src_d     = src_q;
    dst_d     = dst_q;
    sact_d    = sact_q;
    dact_d    = dact_q;
    cnt_d     = cnt_q;
    start_d   = 1'b0;
    irq_d     = 1'b0;
    cdone_d   = 1'b0;
    rdr_start = 1'b0;
    case (st_q)
      ST_IDLE: if (launch) begin
        rdr_start = 1'b1;
        src_d     = init_src;
        dst_d     = init_dst;
        dact_d    = mode[1:0];
        sact_d    = mode[3:2];
        cnt_d     = '0;
        st_d      = ST_FETCH;
      end
      ST_FETCH: if (rdr_done) st_d = chan_en ? ST_LOAD : ST_IDLE;
      ST_LOAD: begin
        src_d   = sel_src;
        dst_d   = sel_dst;
        start_d = 1'b1;
        st_d    = ST_RUN;
      end
      ST_RUN: if (xfer_done) begin
        cnt_d = cnt_q + CNT_W'(1);
        irq_d = chan_en && words[W_CNTIE][IE_BLOCK_BIT];
        st_d  = chan_en ? ST_NEXT : ST_IDLE;
      end
      ST_NEXT: begin
        if (!chan_en) begin
          st_d = ST_IDLE;
        end else if (words[W_NEXT] == CHAIN_END) begin
          cdone_d = 1'b1;
          st_d    = ST_IDLE;
        end else begin
          rdr_start = 1'b1;
          sact_d    = words[W_CTRL][25:24];
          dact_d    = words[W_CTRL][27:26];
          st_d      = ST_FETCH;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q    <= ST_IDLE;
      en_q    <= 1'b0;
      src_q   <= '0;
      dst_q   <= '0;
      sact_q  <= '0;
      dact_q  <= '0;
      cnt_q   <= '0;
      start_q <= 1'b0;
      irq_q   <= 1'b0;
      cdone_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      en_q    <= chan_en;
      src_q   <= src_d;
      dst_q   <= dst_d;
      sact_q  <= sact_d;
      dact_q  <= dact_d;
      cnt_q   <= cnt_d;
      start_q <= start_d;
      irq_q   <= irq_d;
      cdone_q <= cdone_d;
    end
  end

  assign xfer_start     = start_q;
  assign xfer_src_addr  = src_q;
  assign xfer_dst_addr  = dst_q;
  assign xfer_elem_cnt  = words[W_CTRL][23:0];
  assign xfer_frame_cnt = words[W_CNTIE][15:0];
  assign xfer_dst_eidx  = words[W_EIDX][15:0];
  assign xfer_src_eidx  = words[W_EIDX][31:16];
  assign xfer_dst_fidx  = words[W_DFIDX];
  assign xfer_src_fidx  = words[W_SFIDX];
  assign irq_block      = irq_q;
  assign chain_done     = cdone_q;
  assign desc_count     = cnt_q;
  assign busy           = (st_q != ST_IDLE);

  logic unused_ok;
  assign unused_ok = ^{mode[10:9], mode[7:4], words[W_CTRL][31:28],
                       words[W_CNTIE][31:22], words[W_CNTIE][20:16]};

  // R4: start is a single-cycle pulse
  assert_start_pulse_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    xfer_start |=> !xfer_start);
  // R5: addresses stay put in the cycle after start
  assert_addr_stable_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    xfer_start |=> ($stable(xfer_src_addr) && $stable(xfer_dst_addr)));
  // R7: an interrupt follows an accepted done
  assert_irq_after_done_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_block |-> $past(xfer_done));
  // R8: chain completion leaves the block idle
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    chain_done |-> !busy);
  // R9: within a chain the count holds or steps by one
  assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy && $past(busy)) |-> ((desc_count == $past(desc_count)) ||
                               (desc_count == $past(desc_count) + CNT_W'(1))));
endmodule

// File: tb/lldesc_fetcher_tb_top.sv
module lldesc_fetcher_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        en_req = 1'b0, kill_en = 1'b0, chan_en;
  logic [10:0] mode = '0;
  logic [31:0] first_ptr = '0, init_src = '0, init_dst = '0;
  logic        rd_valid, rd_ready = 1'b0, rd_resp_valid = 1'b0;
  logic [31:0] rd_addr, rd_resp_data = '0;
  logic        xfer_start, xfer_done = 1'b0, irq_block, chain_done, busy;
  logic [31:0] xfer_src_addr, xfer_dst_addr, xfer_src_fidx, xfer_dst_fidx;
  logic [23:0] xfer_elem_cnt;
  logic [15:0] xfer_frame_cnt, xfer_src_eidx, xfer_dst_eidx, desc_count;

  assign chan_en = en_req && !kill_en;

  lldesc_fetcher dut_i (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .mode(mode), .first_ptr(first_ptr),
    .init_src(init_src), .init_dst(init_dst), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_addr(rd_addr), .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data),
    .xfer_start(xfer_start), .xfer_done(xfer_done), .xfer_src_addr(xfer_src_addr),
    .xfer_dst_addr(xfer_dst_addr), .xfer_elem_cnt(xfer_elem_cnt), .xfer_frame_cnt(xfer_frame_cnt),
    .xfer_src_eidx(xfer_src_eidx), .xfer_dst_eidx(xfer_dst_eidx), .xfer_src_fidx(xfer_src_fidx),
    .xfer_dst_fidx(xfer_dst_fidx), .irq_block(irq_block), .chain_done(chain_done),
    .desc_count(desc_count), .busy(busy)
  );

  int checks = 0, errors = 0;
  logic [31:0] mem [0:255];
  int n_rd, n_start, n_done, n_irq, n_cdone, stall, dtimer;
  int clr_req = 0, clr_ack = 0;
  bit pend, abort_on_done = 1'b0;
  logic [31:0] pend_addr;
  logic [15:0] irq_mask;
  logic [31:0] rd_log [0:63];
  logic [31:0] s_src [0:15], s_dst [0:15], s_elem [0:15], s_frame [0:15];
  logic [31:0] s_eidx [0:15], s_dfidx [0:15], s_sfidx [0:15];

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  // memory model, engine stub and output monitor
  initial begin
    n_rd = 0; n_start = 0; n_done = 0; n_irq = 0; n_cdone = 0;
    stall = 0; dtimer = 0; pend = 1'b0; pend_addr = '0; irq_mask = '0;
    forever begin
      @(negedge clk);
      if (clr_req != clr_ack) begin
        n_rd = 0; n_start = 0; n_done = 0; n_irq = 0; n_cdone = 0; irq_mask = '0;
        clr_ack = clr_req;
      end
      if (xfer_start) begin
        if (n_start < 16) begin
          s_src[n_start] = xfer_src_addr;  s_dst[n_start] = xfer_dst_addr;
          s_elem[n_start] = 32'(xfer_elem_cnt); s_frame[n_start] = 32'(xfer_frame_cnt);
          s_eidx[n_start] = {xfer_src_eidx, xfer_dst_eidx};
          s_dfidx[n_start] = xfer_dst_fidx; s_sfidx[n_start] = xfer_sfidx_w();
        end
        n_start++;
        dtimer = 2 + n_start % 3;
      end
      if (irq_block) begin
        n_irq++;
        if (n_done > 0 && n_done <= 16) irq_mask[n_done-1] = 1'b1;
      end
      if (chain_done) n_cdone++;
      xfer_done = 1'b0;
      if (dtimer > 0) begin
        dtimer--;
        if (dtimer == 0) begin
          xfer_done = 1'b1;
          n_done++;
          if (abort_on_done) kill_en = 1'b1;
        end
      end
      if (!en_req) kill_en = 1'b0;
      rd_ready = 1'b0;
      rd_resp_valid = 1'b0;
      if (pend) begin
        rd_resp_valid = 1'b1;
        rd_resp_data = mem[pend_addr[9:2]];
        pend = 1'b0;
      end else if (rd_valid) begin
        stall++;
        if (stall % 3 != 1) begin
          rd_ready = 1'b1;
          pend = 1'b1;
          pend_addr = rd_addr;
          if (n_rd < 64) rd_log[n_rd] = rd_addr;
          n_rd++;
        end
      end
    end
  end

  function automatic logic [31:0] xfer_sfidx_w();
    return xfer_src_fidx;
  endfunction

  function automatic logic [31:0] dword(int seed, int j, int nd, int base_w, logic [15:0] ie, int k);
    logic [1:0] sa, da;
    sa = 2'((seed + j) % 4);
    da = 2'((seed + 2*j + 1) % 4);
    case (k)
      0: return (j == nd - 1) ? 32'hFFFF_FFFC : 32'(4 * (base_w + 8 * (j + 1)));
      1: return {3'd2, 1'b0, da, sa, 24'(seed * 4099 + j * 3 + 1)};
      2: return 32'h1000_0000 + 32'(seed << 12) + 32'(j << 4);
      3: return {10'd0, ie[j], 5'd0, 16'(seed * 5 + j + 2)};
      4: return {16'(seed + 7 * j), 16'(1000 - seed - j)};
      5: return 32'(seed * 1000 + j);
      6: return 32'hF000_0000 - 32'(seed * 100 + j);
      default: return '0;
    endcase
  endfunction

  function automatic logic [10:0] mk_mode(logic list, logic [1:0] dp, logic [1:0] sp);
    return {1'b1, 1'b0, list, 2'b00, 2'b10, sp, dp};
  endfunction

  task automatic build(int nd, int base_w, int seed, logic [15:0] ie);
    for (int j = 0; j < nd; j++)
      for (int k = 0; k < 7; k++)
        mem[base_w + 8*j + k] = dword(seed, j, nd, base_w, ie, k);
  endtask

  task automatic clear_logs();
    clr_req++;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int t = 0; t < 3000; t++) begin
      @(negedge clk);
      if (!busy && t > 2) break;
    end
  endtask

  task automatic check_chain(int nd, int base_w, int seed, logic [15:0] ie,
                             logic [1:0] dp, logic [1:0] sp, logic [31:0] s0, logic [31:0] d0);
    logic [31:0] es, ed, w1;
    logic [1:0] sa, da;
    es = s0; ed = d0; sa = sp; da = dp;
    chk("R3 read count", n_rd, 32'(7 * nd));
    for (int j = 0; j < nd; j++)
      for (int k = 0; k < 7; k++)
        chk(j == 0 ? "R3 read address" : "R8 next pointer address",
            rd_log[7*j + k], 32'(4 * (base_w + 8*j) + 4*k));
    chk("R4 start count", n_start, nd);
    for (int j = 0; j < nd; j++) begin
      w1 = dword(seed, j, nd, base_w, ie, 1);
      if (sa == 2'd1) es = dword(seed, j, nd, base_w, ie, 2);
      if (da == 2'd1) ed = dword(seed, j, nd, base_w, ie, 2);
      chk(j == 0 ? "R5 source address" : "R6 source address", s_src[j], es);
      chk(j == 0 ? "R5 destination address" : "R6 destination address", s_dst[j], ed);
      chk("R4 element count", s_elem[j], {8'd0, w1[23:0]});
      chk("R4 frame count", s_frame[j], {16'd0, dword(seed, j, nd, base_w, ie, 3) & 32'h0000_FFFF});
      chk("R4 element indexes", s_eidx[j], dword(seed, j, nd, base_w, ie, 4));
      chk("R4 destination frame index", s_dfidx[j], dword(seed, j, nd, base_w, ie, 5));
      chk("R4 source frame index", s_sfidx[j], dword(seed, j, nd, base_w, ie, 6));
      sa = w1[25:24];
      da = w1[27:26];
    end
    chk("R7 interrupt pattern", 32'(irq_mask), 32'(ie));
    chk("R8 chain done count", n_cdone, 1);
    chk("R9 descriptor count", 32'(desc_count), nd);
    chk("R8 idle after chain", 32'(busy), 0);
  endtask

  task automatic run_chain(int nd, int base_w, int seed, logic [15:0] ie,
                           logic [1:0] dp, logic [1:0] sp);
    build(nd, base_w, seed, ie);
    first_ptr = 32'(4 * base_w);
    init_src = 32'hA000_0000 + 32'(seed);
    init_dst = 32'hB000_0000 + 32'(seed);
    mode = mk_mode(1'b1, dp, sp);
    clear_logs();
    en_req = 1'b1;
    wait_idle();
    en_req = 1'b0;
    repeat (3) @(negedge clk);
    check_chain(nd, base_w, seed, ie, dp, sp, 32'hA000_0000 + 32'(seed), 32'hB000_0000 + 32'(seed));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int rd_snap;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", 32'(busy), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 rd_valid", 32'(rd_valid), 0);
    chk("R1 xfer_start", 32'(xfer_start), 0);
    chk("R1 irq_block", 32'(irq_block), 0);
    chk("R1 chain_done", 32'(chain_done), 0);
    chk("R1 desc_count", 32'(desc_count), 0);

    // R2: list mode clear issues no read
    build(1, 8, 1, 16'h1);
    first_ptr = 32'(4 * 8);
    mode = mk_mode(1'b0, 2'd1, 2'd2);
    clear_logs();
    en_req = 1'b1;
    repeat (20) @(negedge clk);
    chk("R2 no read without list mode", n_rd, 0);
    chk("R2 idle without list mode", 32'(busy), 0);
    en_req = 1'b0;
    repeat (3) @(negedge clk);

    // R5: all action pairs on single descriptors
    for (int i = 0; i < 16; i++)
      run_chain(1, 8 + 8*i, i + 1, 16'(i % 2), 2'(i / 4), 2'(i % 4));

    // R6, R8: multi-descriptor chains
    for (int nd = 2; nd <= 4; nd++)
      run_chain(nd, 160, 40 + nd, (nd == 3) ? 16'b101 : 16'(1 << (nd - 1)), 2'(nd % 4), 2'((nd + 1) % 4));

    // R2: enable held high does not restart
    build(2, 160, 50, 16'b10);
    first_ptr = 32'(4 * 160);
    mode = mk_mode(1'b1, 2'd1, 2'd2);
    clear_logs();
    en_req = 1'b1;
    wait_idle();
    rd_snap = n_rd;
    repeat (30) @(negedge clk);
    chk("R2 no restart while enabled", n_rd, rd_snap);
    chk("R2 idle while enabled", 32'(busy), 0);
    en_req = 1'b0;
    repeat (3) @(negedge clk);

    // R10: abort during fetch
    build(1, 200, 60, 16'h1);
    first_ptr = 32'(4 * 200);
    clear_logs();
    en_req = 1'b1;
    for (int t = 0; t < 200 && n_rd < 3; t++) @(negedge clk);
    en_req = 1'b0;
    repeat (40) @(negedge clk);
    chk("R10 fetch abort no start", n_start, 0);
    chk("R10 fetch abort idle", 32'(busy), 0);
    chk("R10 fetch abort no irq", n_irq, 0);
    chk("R10 fetch abort no chain done", n_cdone, 0);

    // R10: abort when done arrives
    build(2, 160, 70, 16'b11);
    first_ptr = 32'(4 * 160);
    abort_on_done = 1'b1;
    clear_logs();
    en_req = 1'b1;
    wait_idle();
    en_req = 1'b0;
    abort_on_done = 1'b0;
    repeat (10) @(negedge clk);
    chk("R10 done abort single start", n_start, 1);
    chk("R10 done abort no irq", n_irq, 0);
    chk("R10 done abort no chain done", n_cdone, 0);
    chk("R9 count after abort", 32'(desc_count), 1);
    chk("R10 done abort idle", 32'(busy), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule